// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block sits between a handful of external interrupt pins and a small interrupt controller. It brings every pin into the system clock domain through a two-stage synchroniser. The non-maskable input and maskable pin 0 also pass through a minimum pulse-width filter. Each pin is then watched for the event its detection mode defines, and each event is latched into a request flag. The flag stays set until the core sends a one-cycle acknowledge for that source.

Each maskable pin carries a 3-bit priority level, and level 0 switches the source off. From the pending maskable requests, the block presents the one with the highest level, and on a tie the lower-numbered pin wins. The core may be in the short window in which it is entering a deep halt, marked by `halt_entry`. A request that arrives in that window is still latched, but it is marked as held and does not wake the core. Once some later request wakes the core, the held request takes part in priority selection like any other.

The pin roles are fixed by index. Pin 0 detects either a high level or a rising edge. Pins 1 to NPROG detect either a rising or a falling edge, chosen per pin. The remaining pins detect rising edges only. The non-maskable input detects either falling edges only or both edges.

Top module: `xint_cond`

## Requirements
- R1: Every pin is synchronised by two flops. On an unfiltered pin (pins 1 to 4 by default), a qualifying transition sets the pending flag at the third rising clock edge after the pin changes, and not before. On a rising-only pin (index above NPROG), a falling transition sets nothing.
- R2: With `nmi_both_edges`=0, the non-maskable input latches only falling transitions. With `nmi_both_edges`=1, it latches both rising and falling transitions.
- R3: With `pin0_edge_mode`=0, pin 0 requests while its filtered value is high, so an acknowledge given while it is still high leaves the flag set. With `pin0_edge_mode`=1, only a rising transition requests, and an acknowledge clears the flag while the pin stays high.
- R4: For pins 1 to NPROG, bit `prog_fall[i-1]`=0 selects rising-edge detection and bit `prog_fall[i-1]`=1 selects falling-edge detection.
- R5: The non-maskable input and pin 0 accept a new level only after it has been seen for MIN_W (4) consecutive synchronised samples. A pulse of 3 clocks is ignored, and a pulse of 4 clocks is accepted. An accepted transition sets the flag at the seventh rising edge after the pin changes.
- R6: A pending flag holds until its acknowledge (`irq_ack[i]` or `nmi_ack`) is high at a clock edge. If a new event is latched at the same edge as the acknowledge, the flag stays set.
- R7: A maskable pin whose level field `irq_prio[3i+2:3i]` is 0 never sets its flag.
- R8: `sel_valid` is high exactly when some pending pin has a nonzero level. `sel_id` is then the pending pin with the highest level, ties going to the lowest index, and `sel_level` is that level.
- R9: A request latched into a clear flag while `halt_entry` is high sets that source's held bit. The held bit clears when the flag is acknowledged.
- R10: `wake` is high when the non-maskable flag is set and not held, or when some enabled maskable flag is set and not held. Held requests alone leave `wake` low.
- R11: After reset, all flags, held bits, `wake` and `sel_valid` are 0, and every conditioned pin value starts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Asynchronous non-maskable request pin |
| irq_pin | input | NIRQ | Asynchronous maskable request pins |
| nmi_both_edges | input | 1 | 0: falling edges only, 1: both edges |
| pin0_edge_mode | input | 1 | Pin 0: 0 high level, 1 rising edge |
| prog_fall | input | NPROG | Pins 1..NPROG: 0 rising, 1 falling |
| irq_prio | input | NIRQ*3 | 3-bit level per maskable pin, 0 disables |
| halt_entry | input | 1 | High while the core enters deep halt |
| nmi_ack | input | 1 | One-cycle acknowledge of the non-maskable flag |
| irq_ack | input | NIRQ | One-cycle acknowledge per maskable flag |
| nmi_pending | output | 1 | Non-maskable request flag |
| nmi_held | output | 1 | Non-maskable flag latched in the halt window |
| irq_pending | output | NIRQ | Maskable request flags |
| irq_held | output | NIRQ | Maskable flags latched in the halt window |
| wake | output | 1 | Some non-held request can wake the core |
| sel_valid | output | 1 | A selectable maskable request exists |
| sel_id | output | IDW | Index of the selected request |
| sel_level | output | 3 | Level of the selected request |

## Verification
Each detection mode is driven with rising and falling transitions, so that the bench tells rising-only, falling-only, both-edge and level behaviour apart. Each result is sampled at the exact edge where it must first appear. On the filtered inputs, pulses of 3 and 4 clocks separate a filter that is too short from one that is too long. The selector is swept over all 32768 level assignments with all pins pending, and again with a sparse pending set, which exposes errors in tie-breaking, in the disable rule and in the masking of non-pending pins. A halt-window scenario checks that a held request does not raise `wake`, and that it still wins selection once a later request arrives.

// File: rtl/xint_pkg.sv
package xint_pkg;
  typedef enum logic [1:0] {
    DET_RISE  = 2'd0,
    DET_FALL  = 2'd1,
    DET_BOTH  = 2'd2,
    DET_LEVEL = 2'd3
  } det_mode_e;

  // Event for one conditioned sample pair under a detection mode.
  function automatic logic det_event(det_mode_e mode, logic cur, logic prv);
    case (mode)
      DET_RISE:  det_event = cur & ~prv;
      DET_FALL:  det_event = ~cur & prv;
      DET_BOTH:  det_event = cur ^ prv;
      default:   det_event = cur;
    endcase
  endfunction
endpackage

// File: rtl/xint_sync_filt.sv
module xint_sync_filt #(
  parameter int MIN_W  = 4,
  parameter bit FILTER = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic cond_o,
  output logic prev_o
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
    end
  end

  generate
    if (FILTER) begin : g_filt
      localparam int CW = $clog2(MIN_W + 1);
      logic [CW-1:0] cnt;
      logic          filt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt  <= '0;
          filt <= 1'b0;
        end else if (s2 == filt) begin
          cnt <= '0;
        end else if (cnt == CW'(MIN_W - 1)) begin
          filt <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign cond_o = filt;
    end else begin : g_raw
      assign cond_o = s2;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= 1'b0;
    else        prev_o <= cond_o;
  end
endmodule

// File: rtl/xint_latch.sv
module xint_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic halt_i,
  output logic pend_o,
  output logic held_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      held_o <= 1'b0;
    end else if (set_i) begin
      pend_o <= 1'b1;
      if (!pend_o || ack_i) held_o <= halt_i;
    end else if (ack_i) begin
      pend_o <= 1'b0;
      held_o <= 1'b0;
    end
  end
endmodule

// File: rtl/xint_prio.sv
module xint_prio #(
  parameter int NIRQ  = 5,
  parameter int LVL_W = 3,
  localparam int IDW  = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0]       pend_i,
  input  logic [NIRQ*LVL_W-1:0] lvl_i,
  output logic                  valid_o,
  output logic [IDW-1:0]        id_o,
  output logic [LVL_W-1:0]      lvl_o
);
  always_comb begin
    lvl_o = '0;
    id_o  = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (pend_i[i] && (lvl_i[i*LVL_W +: LVL_W] > lvl_o)) begin
        lvl_o = lvl_i[i*LVL_W +: LVL_W];
        id_o  = IDW'(i);
      end
    end
    valid_o = (lvl_o != '0);
  end
endmodule

// File: rtl/xint_cond.sv
module xint_cond
  import xint_pkg::*;
#(
  parameter int NIRQ  = 5,
  parameter int NPROG = 2,
  parameter int MIN_W = 4,
  parameter int LVL_W = 3,
  localparam int IDW  = $clog2(NIRQ)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nmi_pin,
  input  logic [NIRQ-1:0]       irq_pin,
  input  logic                  nmi_both_edges,
  input  logic                  pin0_edge_mode,
  input  logic [NPROG-1:0]      prog_fall,
  input  logic [NIRQ*LVL_W-1:0] irq_prio,
  input  logic                  halt_entry,
  input  logic                  nmi_ack,
  input  logic [NIRQ-1:0]       irq_ack,
  output logic                  nmi_pending,
  output logic                  nmi_held,
  output logic [NIRQ-1:0]       irq_pending,
  output logic [NIRQ-1:0]       irq_held,
  output logic                  wake,
  output logic                  sel_valid,
  output logic [IDW-1:0]        sel_id,
  output logic [LVL_W-1:0]      sel_level
);
  // Named internal events, observed by the bound checker.
  logic            ev_nmi;
  logic [NIRQ-1:0] ev_irq;
  logic [NIRQ-1:0] irq_en;

  logic      nmi_cond, nmi_prev;
  det_mode_e nmi_mode;

  assign nmi_mode = nmi_both_edges ? DET_BOTH : DET_FALL;

  xint_sync_filt #(.MIN_W(MIN_W), .FILTER(1'b1)) u_nmi_sf (
    .clk(clk), .rst_n(rst_n), .pin_i(nmi_pin),
    .cond_o(nmi_cond), .prev_o(nmi_prev)
  );

  assign ev_nmi = det_event(nmi_mode, nmi_cond, nmi_prev);

  xint_latch u_nmi_lat (
    .clk(clk), .rst_n(rst_n), .set_i(ev_nmi), .ack_i(nmi_ack),
    .halt_i(halt_entry), .pend_o(nmi_pending), .held_o(nmi_held)
  );

  for (genvar i = 0; i < NIRQ; i++) begin : g_pin
    logic      cond, prev;
    det_mode_e mode;

    if (i == 0) begin : g_m0
      assign mode = pin0_edge_mode ? DET_RISE : DET_LEVEL;
    end else if (i <= NPROG) begin : g_mp
      assign mode = prog_fall[i-1] ? DET_FALL : DET_RISE;
    end else begin : g_mr
      assign mode = DET_RISE;
    end

    xint_sync_filt #(.MIN_W(MIN_W), .FILTER(i == 0)) u_sf (
      .clk(clk), .rst_n(rst_n), .pin_i(irq_pin[i]),
      .cond_o(cond), .prev_o(prev)
    );

    assign irq_en[i] = (irq_prio[i*LVL_W +: LVL_W] != '0);
    assign ev_irq[i] = irq_en[i] & det_event(mode, cond, prev);

    xint_latch u_lat (
      .clk(clk), .rst_n(rst_n), .set_i(ev_irq[i]), .ack_i(irq_ack[i]),
      .halt_i(halt_entry), .pend_o(irq_pending[i]), .held_o(irq_held[i])
    );
  end

  assign wake = (nmi_pending & ~nmi_held) | (|(irq_pending & ~irq_held & irq_en));

  xint_prio #(.NIRQ(NIRQ), .LVL_W(LVL_W)) u_prio (
    .pend_i(irq_pending), .lvl_i(irq_prio),
    .valid_o(sel_valid), .id_o(sel_id), .lvl_o(sel_level)
  );
endmodule

// File: rtl/xint_cond_chk.sv
module xint_cond_chk #(
  parameter int NIRQ  = 5,
  parameter int LVL_W = 3,
  localparam int IDW  = $clog2(NIRQ)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  halt_entry,
  input logic                  nmi_ack,
  input logic [NIRQ-1:0]       irq_ack,
  input logic [NIRQ*LVL_W-1:0] irq_prio,
  input logic                  ev_nmi,
  input logic [NIRQ-1:0]       ev_irq,
  input logic                  nmi_pending,
  input logic                  nmi_held,
  input logic [NIRQ-1:0]       irq_pending,
  input logic [NIRQ-1:0]       irq_held,
  input logic                  wake,
  input logic                  sel_valid,
  input logic [IDW-1:0]        sel_id,
  input logic [LVL_W-1:0]      sel_level
);
  p_nmi_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !ev_nmi) |=> !nmi_pending);

  p_nmi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nmi && halt_entry && !nmi_pending) |=> nmi_held);

  p_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ((sel_level != '0) && (|(irq_pending & (NIRQ'(1) << sel_id)))));

  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (nmi_pending || (|irq_pending)));

  for (genvar i = 0; i < NIRQ; i++) begin : g_chk
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[i] && !ev_irq[i]) |=> !irq_pending[i]);

    p_hold_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_irq[i] && halt_entry && !irq_pending[i]) |=> irq_held[i]);

    p_held_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_held[i] |-> irq_pending[i]);

    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_prio[i*LVL_W +: LVL_W] == '0) && !irq_pending[i]) |=> !irq_pending[i]);
  end
endmodule

bind xint_cond xint_cond_chk #(.NIRQ(NIRQ), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_entry(halt_entry), .nmi_ack(nmi_ack),
  .irq_ack(irq_ack), .irq_prio(irq_prio), .ev_nmi(ev_nmi), .ev_irq(ev_irq),
  .nmi_pending(nmi_pending), .nmi_held(nmi_held), .irq_pending(irq_pending),
  .irq_held(irq_held), .wake(wake), .sel_valid(sel_valid), .sel_id(sel_id),
  .sel_level(sel_level)
);

// File: tb/xint_cond_tb.sv
`timescale 1ns/1ps
module xint_cond_tb;
  localparam int NIRQ = 5;
  localparam int NPROG = 2;
  localparam int LVL_W = 3;
  localparam int IDW = $clog2(NIRQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 1'b0;
  logic [NIRQ-1:0] irq_pin = '0;
  logic nmi_both_edges = 1'b0;
  logic pin0_edge_mode = 1'b0;
  logic [NPROG-1:0] prog_fall = '0;
  logic [NIRQ*LVL_W-1:0] irq_prio = '1;
  logic halt_entry = 1'b0;
  logic nmi_ack = 1'b0;
  logic [NIRQ-1:0] irq_ack = '0;
  logic nmi_pending, nmi_held, wake, sel_valid;
  logic [NIRQ-1:0] irq_pending, irq_held;
  logic [IDW-1:0] sel_id;
  logic [LVL_W-1:0] sel_level;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xint_cond #(.NIRQ(NIRQ), .NPROG(NPROG), .MIN_W(4), .LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
    .nmi_both_edges(nmi_both_edges), .pin0_edge_mode(pin0_edge_mode),
    .prog_fall(prog_fall), .irq_prio(irq_prio), .halt_entry(halt_entry),
    .nmi_ack(nmi_ack), .irq_ack(irq_ack), .nmi_pending(nmi_pending),
    .nmi_held(nmi_held), .irq_pending(irq_pending), .irq_held(irq_held),
    .wake(wake), .sel_valid(sel_valid), .sel_id(sel_id), .sel_level(sel_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Wait n rising edges, then sample just after the last one.
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ack_irq(input logic [NIRQ-1:0] m);
    @(negedge clk) irq_ack = m;
    @(negedge clk) irq_ack = '0;
    #1;
  endtask

  task automatic ack_nmi();
    @(negedge clk) nmi_ack = 1'b1;
    @(negedge clk) nmi_ack = 1'b0;
    #1;
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk) irq_pin[i] = v;
  endtask

  // Selector sweep over every level assignment; expectation scans levels downward.
  task automatic sweep(input string tag);
    for (int p = 0; p < (1 << (NIRQ*LVL_W)); p++) begin
      logic ev;
      int   eid;
      int   el;
      @(negedge clk) irq_prio = p[NIRQ*LVL_W-1:0];
      #1;
      ev = 1'b0; eid = 0; el = 0;
      for (int lv = 7; lv >= 1 && !ev; lv--) begin
        for (int i = 0; i < NIRQ && !ev; i++) begin
          if (irq_pending[i] && ((p >> (i*LVL_W)) & 7) == lv) begin
            ev = 1'b1; eid = i; el = lv;
          end
        end
      end
      check({tag, " R8 valid"}, 32'(sel_valid), 32'(ev));
      if (ev) begin
        check({tag, " R8 id"}, 32'(sel_id), 32'(eid));
        check({tag, " R8 level"}, 32'(sel_level), 32'(el));
      end
    end
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    check("R11 nmi_pending", 32'(nmi_pending), 0);
    check("R11 irq_pending", 32'(irq_pending), 0);
    check("R11 wake", 32'(wake), 0);
    check("R11 sel_valid", 32'(sel_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    edges(3);
    check("R11 after release", 32'(irq_pending), 0);

    // R1: rising-only pin 3 latency and falling ignored
    set_pin(3, 1'b1);
    edges(2);
    check("R1 not before third edge", 32'(irq_pending[3]), 0);
    edges(1);
    check("R1 set at third edge", 32'(irq_pending[3]), 1);
    check("R10 wake from pending", 32'(wake), 1);
    ack_irq(5'b01000);
    check("R6 ack clears", 32'(irq_pending[3]), 0);
    set_pin(3, 1'b0);
    edges(5);
    check("R1 fall ignored on rising-only pin", 32'(irq_pending[3]), 0);
    check("R10 wake low when idle", 32'(wake), 0);

    // R4: programmable pins
    prog_fall = 2'b01;
    set_pin(1, 1'b1);
    edges(5);
    check("R4 pin1 falling mode ignores rise", 32'(irq_pending[1]), 0);
    set_pin(1, 1'b0);
    edges(2);
    check("R4 pin1 not early", 32'(irq_pending[1]), 0);
    edges(1);
    check("R4 pin1 falling detected", 32'(irq_pending[1]), 1);
    ack_irq(5'b00010);
    set_pin(2, 1'b1);
    edges(3);
    check("R4 pin2 rising detected", 32'(irq_pending[2]), 1);
    ack_irq(5'b00100);
    set_pin(2, 1'b0);
    edges(5);
    check("R4 pin2 rising mode ignores fall", 32'(irq_pending[2]), 0);

    // R2/R5: non-maskable input
    @(negedge clk) nmi_pin = 1'b1;
    edges(10);
    check("R2 falling-only ignores rise", 32'(nmi_pending), 0);
    @(negedge clk) nmi_pin = 1'b0;
    edges(6);
    check("R5 filtered not before seventh edge", 32'(nmi_pending), 0);
    edges(1);
    check("R5 filtered set at seventh edge", 32'(nmi_pending), 1);
    ack_nmi();
    check("R6 nmi ack clears", 32'(nmi_pending), 0);
    nmi_both_edges = 1'b1;
    @(negedge clk) nmi_pin = 1'b1;
    edges(7);
    check("R2 both-edge mode latches rise", 32'(nmi_pending), 1);
    ack_nmi();
    edges(8);
    @(negedge clk) nmi_pin = 1'b0;
    repeat (3) @(negedge clk);
    nmi_pin = 1'b1;
    edges(12);
    check("R5 3-clock pulse rejected", 32'(nmi_pending), 0);
    @(negedge clk) nmi_pin = 1'b0;
    repeat (4) @(negedge clk);
    nmi_pin = 1'b1;
    edges(14);
    check("R5 4-clock pulse accepted", 32'(nmi_pending), 1);
    ack_nmi();
    edges(2);
    check("R6 nmi stays clear", 32'(nmi_pending), 0);

    // R3: pin 0 level then edge mode
    set_pin(0, 1'b1);
    edges(6);
    check("R3 level not before seventh edge", 32'(irq_pending[0]), 0);
    edges(1);
    check("R3 level latched", 32'(irq_pending[0]), 1);
    ack_irq(5'b00001);
    check("R3 level re-asserts after ack", 32'(irq_pending[0]), 1);
    set_pin(0, 1'b0);
    edges(10);
    ack_irq(5'b00001);
    edges(3);
    check("R3 level clears once pin low", 32'(irq_pending[0]), 0);
    pin0_edge_mode = 1'b1;
    set_pin(0, 1'b1);
    edges(7);
    check("R3 edge mode latches rise", 32'(irq_pending[0]), 1);
    ack_irq(5'b00001);
    edges(3);
    check("R3 edge mode clears while high", 32'(irq_pending[0]), 0);
    set_pin(0, 1'b0);
    edges(10);

    // R7: level 0 disables
    irq_prio[4*LVL_W +: LVL_W] = 3'd0;
    set_pin(4, 1'b1);
    edges(5);
    check("R7 disabled pin sets nothing", 32'(irq_pending[4]), 0);
    set_pin(4, 1'b0);
    edges(4);
    irq_prio = '1;

    // R6: event at the same edge as ack keeps the flag
    set_pin(3, 1'b1);
    edges(4);
    set_pin(3, 1'b0);
    edges(4);
    check("R6 flag held without ack", 32'(irq_pending[3]), 1);
    @(negedge clk) irq_pin[3] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) irq_ack = 5'b01000;
    @(posedge clk);
    #1;
    check("R6 event beats ack", 32'(irq_pending[3]), 1);
    @(negedge clk) irq_ack = '0;
    ack_irq(5'b01000);
    check("R6 later ack clears", 32'(irq_pending[3]), 0);
    set_pin(3, 1'b0);
    edges(4);

    // R9/R10: halt window
    irq_prio = '0;
    irq_prio[2*LVL_W +: LVL_W] = 3'd6;
    irq_prio[3*LVL_W +: LVL_W] = 3'd2;
    @(negedge clk) halt_entry = 1'b1;
    irq_pin[2] = 1'b1;
    edges(3);
    check("R9 held request pending", 32'(irq_pending[2]), 1);
    check("R9 held bit set", 32'(irq_held[2]), 1);
    check("R10 held request does not wake", 32'(wake), 0);
    @(negedge clk) halt_entry = 1'b0;
    irq_pin[3] = 1'b1;
    edges(3);
    check("R10 later request wakes", 32'(wake), 1);
    check("R9 held still set", 32'(irq_held[2]), 1);
    check("R9 held served first", 32'(sel_id), 2);
    check("R8 level of held", 32'(sel_level), 6);
    ack_irq(5'b00100);
    check("R9 held cleared by ack", 32'(irq_held[2]), 0);
    check("R8 next selected", 32'(sel_id), 3);
    ack_irq(5'b01000);
    set_pin(2, 1'b0);
    set_pin(3, 1'b0);
    edges(4);

    // R8: sweeps
    irq_prio = '1;
    prog_fall = '0;
    @(negedge clk) irq_pin = '1;
    edges(10);
    check("R8 all pending", 32'(irq_pending), 32'h1F);
    sweep("full");
    ack_irq(5'b01010);
    check("R8 sparse pending", 32'(irq_pending), 32'h15);
    sweep("sparse");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule